// File: doc/BRIEF.md
# Burst Word Address Sequencer

This block produces the word address for a synchronous SRAM during bursts. On a load, it captures a full external address. The low two bits of that address become the burst start offset. On each later advance request, the low bits step to the next beat of the burst, and the upper bits stay as captured. A burst is four beats long and then wraps back to its start offset.

Two beat orders are available, chosen by a static order-select input:

- **Linear order:** adds the beat count to the start offset, modulo four.
- **Interleaved order:** XORs the start offset with the beat count.

The order select is not registered. It acts combinationally on the address output and must be held steady while the block is in use.

A stall input freezes all internal state. While it is high, both load and advance are ignored.

The control pins are plain level-sampled strobes. No data stream enters or leaves the block, so it has no valid/ready handshake and no back-pressure.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and after reset until the first load, `word_addr` is all zeros.
- R2: At a rising edge with `stall` low and `load` high, the block captures `addr_in`. From that edge, `word_addr` equals the captured address, and the beat count restarts at 0.
- R3: With `order_sel` = 0 (linear), after k advances since the last load, the low two bits of `word_addr` equal (start + k) mod 4. For example, a start of 1 gives 1, 2, 3, 0.
- R4: With `order_sel` = 1 (interleaved), after k advances since the last load, the low two bits of `word_addr` equal start XOR (k mod 4). For example, a start of 1 gives 1, 0, 3, 2.
- R5: After four advances, the low bits return to the start offset (wrap), in either order.
- R6: Bits [ADDR_W-1:2] of `word_addr` change only at an edge where a load is accepted.
- R7: At an edge where `stall` is high, nothing changes: the block ignores `load`, `adv` and `addr_in`.
- R8: At an edge with `stall`, `load` and `adv` all low, the address and the beat count hold.
- R9: `order_sel` is not registered. A change on it alters the low bits of `word_addr` without any clock edge.
- R10: When `load` and `adv` are both high and `stall` is low, the load wins and the beat count restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | High freezes all state at the edge |
| load | input | 1 | Capture `addr_in` as a new burst start |
| adv | input | 1 | Step to the next beat of the burst |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order; static and not registered |
| addr_in | input | ADDR_W | External word address |
| word_addr | output | ADDR_W | Current word address |

## Verification
Load, advance, hold and stall take effect at the rising edge where they are sampled. Their result on `word_addr` is therefore due after that edge with no further latency. The bench drives every input at a falling edge, updates its own address model at the next rising edge, and compares at the following falling edge.

A change on `order_sel` is due at once, with no edge. The bench checks it one time step after the change, before any further clock edge.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_q,
  output logic [OFS_W-1:0]  beat_q
);
  logic take_load;
  logic take_step;

  assign take_load = !stall && load;
  assign take_step = !stall && !load && adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (take_load) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (take_step) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  // R7
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(beat_q) && $stable(base_q)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !load && !adv) |=> ($stable(beat_q) && $stable(base_q)));

  // R3
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !load && adv) |=> (beat_q == OFS_W'($past(beat_q) + 1'b1)));

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && load && adv) |=> (beat_q == '0));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic [OFS_W-1:0] start,
  input  logic [OFS_W-1:0] beat,
  input  burst_order_e     order,
  output logic [OFS_W-1:0] low
);
  logic [OFS_W-1:0] lin_ofs;
  logic [OFS_W-1:0] xor_ofs;

  assign lin_ofs = start + beat;
  assign xor_ofs = start ^ beat;

  always_comb begin
    unique case (order)
      ORD_LINEAR: low = lin_ofs;
      ORD_XOR:    low = xor_ofs;
      default:    low = lin_ofs;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              load,
  input  logic              adv,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int UP_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] base_q;
  logic [OFS_W-1:0]  beat_q;
  logic [OFS_W-1:0]  low_ofs;
  burst_order_e      order;

  assign order = burst_order_e'(order_sel);

  burst_beat_ctr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall   (stall),
    .load    (load),
    .adv     (adv),
    .addr_in (addr_in),
    .base_q  (base_q),
    .beat_q  (beat_q)
  );

  burst_order_map #(.OFS_W(OFS_W)) u_map (
    .start (base_q[OFS_W-1:0]),
    .beat  (beat_q),
    .order (order),
    .low   (low_ofs)
  );

  assign word_addr = {base_q[ADDR_W-1:OFS_W], low_ofs};

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && load) |=> (word_addr == $past(addr_in)));

  // R6
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || !load) |=> $stable(word_addr[ADDR_W-1:OFS_W]));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |-> (word_addr == '0));

  initial begin
    // R6
    width_ok_chk: assert (UP_W > 0);
  end
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b0;
  logic          load = 1'b0;
  logic          adv = 1'b0;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] word_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;

  burst_addr_seq #(.ADDR_W(AW), .OFS_W(2)) uut (
    .clk, .rst_n, .stall, .load, .adv, .order_sel, .addr_in, .word_addr
  );

  always #5 clk = ~clk;

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] k, logic ilv);
    logic [1:0] lo;
    lo = ilv ? (b[1:0] ^ k) : (b[1:0] + k);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic s, logic l, logic a, logic [AW-1:0] ad, string tag);
    stall = s; load = l; adv = a; addr_in = ad;
    @(posedge clk);
    if (!s && l) begin m_base = ad; m_beat = '0; end
    else if (!s && a) m_beat = m_beat + 1'b1;
    @(negedge clk);
    check(tag, word_addr, exp_addr(m_base, m_beat, order_sel));
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    check("R1 in reset", word_addr, '0);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 20'hABCDE, "R1 after reset");

    // R3 linear from start 1, then R5 wrap and R6 upper
    order_sel = 1'b0;
    step(0, 1, 0, 20'h12341, "R2 load");
    for (int i = 0; i < 3; i++) step(0, 0, 1, '0, "R3 linear step");
    check("R3 linear beat 3 value", word_addr, 20'h12340);
    step(0, 0, 1, '0, "R5 wrap linear");
    check("R5 wrap returns start", word_addr, 20'h12341);
    check("R6 upper fixed", {word_addr[AW-1:2], 2'b00}, 20'h12340);

    // R4 interleaved from start 1
    order_sel = 1'b1;
    step(0, 1, 0, 20'h55551, "R2 load");
    step(0, 0, 1, '0, "R4 xor step");
    check("R4 xor beat 1 value", word_addr, 20'h55550);
    step(0, 0, 1, '0, "R4 xor step");
    check("R4 xor beat 2 value", word_addr, 20'h55553);
    step(0, 0, 1, '0, "R4 xor step");
    step(0, 0, 1, '0, "R5 wrap xor");
    check("R5 wrap xor returns start", word_addr, 20'h55551);

    // R9 order select acts without a clock
    step(0, 1, 0, 20'h00A01, "R2 load");
    step(0, 0, 1, '0, "R4 xor step");
    order_sel = 1'b0;
    #1;
    check("R9 switch to linear", word_addr, 20'h00A02);
    order_sel = 1'b1;
    #1;
    check("R9 switch to xor", word_addr, 20'h00A00);

    // R7 stall blocks load and advance; R8 idle hold; R10 load priority
    step(1, 1, 0, 20'hFFFFF, "R7 stall blocks load");
    step(1, 0, 1, '0, "R7 stall blocks adv");
    step(0, 0, 0, 20'h33333, "R8 idle hold");
    step(0, 1, 1, 20'h0BEE2, "R10 load beats adv");
    check("R10 load value", word_addr, 20'h0BEE2);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic s, l, a;
      logic [AW-1:0] ad;
      s = ($urandom % 5) == 0;
      l = ($urandom % 4) == 0;
      a = ($urandom % 3) != 0;
      ad = AW'($urandom);
      if (($urandom % 50) == 0) order_sel = ~order_sel;
      if (s)      step(s, l, a, ad, "R7 random stall");
      else if (l) step(s, l, a, ad, "R2 random load");
      else if (a) step(s, l, a, ad, order_sel ? "R4 random xor" : "R3 random linear");
      else        step(s, l, a, ad, "R8 random idle");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule